// File: doc/BRIEF.md
# Address Translation Unit Register Block

This block is the software-visible register file of an I/O address translation unit. A host reaches it through a single-cycle port that addresses 32-bit words, so the port index is the byte offset shifted right by two. Each register has its own write mask and its own hard-wired bits, and each is applied on the clock edge that accepts the write. The register space is 4K words deep. It is decoded sparsely: word offsets with no register read as zero, and writes to them are dropped.

The block also serves the translator next to it. A write to the control register decodes the 3-bit range field into the start address of the translated window, and that start is held on an output until the next control write. A fault-capture input from the translator records an error status word and the faulting page address, and it raises a level interrupt. Software lowers the interrupt by reading or writing either error register.

Read data is combinational on the word index. A read side effect only takes place when a read is actually issued, that is with the enable high and the write flag low.

Top module: `dvma_csr`

## Requirements
- R1: After synchronous active-low reset, every register reads zero except these: control reads {VERSION, 24'h0}, arbiter enable reads 0x00000003, error status reads 0x00800000, arbitration enable reads 0x00000008 and mask-ID reads 0x23000000. `win_start` is 0 and `irq` is 0.
- R2: Control is at word 0x000. Only bits 0, 2, 3 and 4 are writable (mask 0x0000001D). Bits 31:24 always read back as the VERSION parameter. `xlat_en` follows control bit 0.
- R3: A control write loads `win_start` with 0xFFFFFFFF << (24 + code), where code is the written value's bits 4:2. Code 0 gives 0xFF000000 and code 7 gives 0x80000000. `win_start` changes only on a control write, and its low 24 bits are always zero.
- R4: The table base at word 0x001 keeps only bits 0x07FFFC00 of a write. The full-flush register at word 0x005 and the single-page-flush register at word 0x006 keep all 32 written bits.
- R5: A write to error status (word 0x400) stores (value & 0xFF0FFFFF) | 0x00800000. A write to error address (word 0x401) stores all 32 bits. Bit 23 of error status always reads one.
- R6: A read or a write of word 0x400 or 0x401 lowers `irq` in the next cycle, unless a fault is captured in the same cycle.
- R7: A `fault_pulse` cycle has these effects from the next cycle onwards. Error status holds 0xC0820000, or 0xC0860000 when `fault_rd` is 1. Error address holds `fault_addr` with its low PAGE_SHIFT bits cleared. `irq` is 1. A fault takes priority over a same-cycle write to, or read of, the error registers.
- R8: Arbiter enable (word 0x402) keeps bits 0x801F000F of a write, and bit 0 always reads one.
- R9: The four slot configuration words 0x404 to 0x407 each keep bits 0x00010003 of a write, independently of each other.
- R10: Arbitration enable (word 0x800) keeps bits 0x001F0000 of a write, and bit 3 always reads one.
- R11: A write to mask-ID (word 0xC06) ORs in (value & 0x00FFFFFF). No bit of mask-ID is ever cleared by a write.
- R12: Any word index not listed above reads zero, and a write to it changes no register.
- R13: Without a fault and without an access to word 0x400 or 0x401, `irq` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_en | input | 1 | Access strobe, one access per cycle |
| acc_wr | input | 1 | 1 selects a write, 0 selects a read |
| acc_word | input | WORD_AW | Word index (byte offset >> 2) |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data of the word at `acc_word` (combinational) |
| fault_pulse | input | 1 | One-cycle fault capture from the translator |
| fault_rd | input | 1 | Faulting access was a read |
| fault_addr | input | 32 | Faulting address |
| win_start | output | 32 | Start address of the translated window |
| xlat_en | output | 1 | Translation enable (control bit 0) |
| irq | output | 1 | Level error interrupt |

## Verification
Every writable register gets three kinds of pattern: a walking one across all 32 bit positions, all-ones, and all-zeros. The walking one separates kept bits from dropped ones, and the all-zeros write exposes hard-wired bits that a plain mask would lose. The range field is swept over all eight codes, each followed by a different code, so a stuck or shifted decode shows up as a wrong window start. The interrupt is driven through each way of lowering it: a side-effect read and a write of each error register, a plain look that must not lower it, a same-cycle fault that must win, and a read-flavoured and a write-flavoured fault, which tell bit 18 apart.

// File: rtl/dvma_csr_pkg.sv
// Package: word offsets, write masks and forced bits of the translation
// unit register block. Assumes 32-bit data and word-granular offsets.
package dvma_csr_pkg;

    // word offsets (byte offset >> 2)
    localparam logic [31:0] W_CTRL    = 32'h000;
    localparam logic [31:0] W_TBASE   = 32'h001;
    localparam logic [31:0] W_FLALL   = 32'h005;
    localparam logic [31:0] W_FLPAGE  = 32'h006;
    localparam logic [31:0] W_ESTAT   = 32'h400;
    localparam logic [31:0] W_EADDR   = 32'h401;
    localparam logic [31:0] W_ARBMSK  = 32'h402;
    localparam logic [31:0] W_SLOT0   = 32'h404;
    localparam logic [31:0] W_ARBON   = 32'h800;
    localparam logic [31:0] W_MASKID  = 32'hC06;

    // write masks
    localparam logic [31:0] M_CTRL    = 32'h0000_001D;
    localparam logic [31:0] M_TBASE   = 32'h07FF_FC00;
    localparam logic [31:0] M_ESTAT   = 32'hFF0F_FFFF;
    localparam logic [31:0] M_ARBMSK  = 32'h801F_000F;
    localparam logic [31:0] M_SLOT    = 32'h0001_0003;
    localparam logic [31:0] M_ARBON   = 32'h001F_0000;
    localparam logic [31:0] M_MASKID  = 32'h00FF_FFFF;

    // forced and reset bits
    localparam logic [31:0] F_ESTAT   = 32'h0080_0000;
    localparam logic [31:0] F_ARBMSK  = 32'h0000_0001;
    localparam logic [31:0] F_ARBON   = 32'h0000_0008;
    localparam logic [31:0] RST_ARBMSK = 32'h0000_0003;
    localparam logic [31:0] RST_MASKID = 32'h2300_0000;

    // fault capture status bits
    localparam logic [31:0] S_ERR     = 32'h8000_0000;
    localparam logic [31:0] S_LATE    = 32'h4000_0000;
    localparam logic [31:0] S_READ    = 32'h0004_0000;
    localparam logic [31:0] S_AVALID  = 32'h0002_0000;

    // status word loaded by a fault capture
    function automatic logic [31:0] fault_status(input logic is_rd);
        return S_ERR | S_LATE | F_ESTAT | S_AVALID | (is_rd ? S_READ : 32'h0);
    endfunction

endpackage

// File: rtl/dvma_win_dec.sv
// Window decoder: turns the 3-bit range code into the lowest address of a
// window that reaches the top of the 32-bit space. The smallest window is
// 2**MIN_LOG2 bytes, and each code step doubles it.
// Assumes MIN_LOG2 + 7 <= 31.
module dvma_win_dec #(
    parameter int MIN_LOG2 = 24
) (
    input  logic [2:0]  code,
    output logic [31:0] start
);
    localparam int SHIFT_W = 5;

    logic [SHIFT_W-1:0] shamt;

    // shift amount = log2 of the window size
    always_comb shamt = SHIFT_W'(MIN_LOG2) + SHIFT_W'(code);

    // window start = all ones with the low log2(size) bits cleared
    always_comb start = 32'hFFFF_FFFF << shamt;

    // p_win_top_r3: every decoded start leaves at least the smallest window
    always_comb begin
        p_win_top_r3: assert (start[MIN_LOG2-1:0] == '0);
    end
endmodule

// File: rtl/dvma_fault_ctl.sv
// Error capture: holds the error status and error address words and the
// level interrupt. A fault capture takes priority over software writes and
// over clearing by access in the same cycle. Assumes one access per cycle.
module dvma_fault_ctl
    import dvma_csr_pkg::*;
#(
    parameter int PAGE_SHIFT = 12
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        stat_wr,
    input  logic        addr_wr,
    input  logic        err_touch,
    input  logic [31:0] wdata,
    input  logic        fault_pulse,
    input  logic        fault_rd,
    input  logic [31:0] fault_addr,
    output logic [31:0] stat_q,
    output logic [31:0] addr_q,
    output logic        irq
);
    localparam logic [31:0] PAGE_MASK = 32'hFFFF_FFFF << PAGE_SHIFT;

    // error status: reset value, fault capture, or masked write with bit 23 forced
    always_ff @(posedge clk) begin
        if (!rst_n)           stat_q <= F_ESTAT;
        else if (fault_pulse) stat_q <= fault_status(fault_rd);
        else if (stat_wr)     stat_q <= (wdata & M_ESTAT) | F_ESTAT;
    end

    // error address: page-aligned fault address, or full write
    always_ff @(posedge clk) begin
        if (!rst_n)           addr_q <= '0;
        else if (fault_pulse) addr_q <= fault_addr & PAGE_MASK;
        else if (addr_wr)     addr_q <= wdata;
    end

    // interrupt: set by fault, lowered by any access to the error words
    always_ff @(posedge clk) begin
        if (!rst_n)           irq <= 1'b0;
        else if (fault_pulse) irq <= 1'b1;
        else if (err_touch)   irq <= 1'b0;
    end

    // p_irq_raise_r7: a fault raises the line
    p_irq_raise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fault_pulse |=> irq);
    // p_irq_lower_r6: an error-register access without a fault lowers it
    p_irq_lower_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (err_touch && !fault_pulse) |=> !irq);
    // p_irq_hold_r13: nothing else moves it
    p_irq_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (!err_touch && !fault_pulse && $past(rst_n)) |=> $stable(irq));
    // p_stat_resv_r5: bit 23 of error status is always one
    p_stat_resv_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> stat_q[23]);
endmodule

// File: rtl/dvma_cfg_regs.sv
// Configuration registers: control, table base, flush words, arbiter
// enable, per-slot configuration, arbitration enable and mask-ID. Gives
// read data and a hit flag for the word it is asked about. Assumes the
// word index is zero-extended to 32 bits by the caller.
module dvma_cfg_regs
    import dvma_csr_pkg::*;
#(
    parameter logic [7:0] VERSION   = 8'h41,
    parameter int         NUM_SLOTS = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [31:0] word,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    output logic        hit,
    output logic [4:0]  ctrl_lo
);
    logic [4:0]  ctrl_q;
    logic [31:0] tbase_q, flall_q, flpage_q, arbmsk_q, arbon_q, maskid_q;
    logic [31:0] slot_q [NUM_SLOTS];
    logic [NUM_SLOTS-1:0] slot_hit;

    // control: only the writable low bits are stored
    always_ff @(posedge clk) begin
        if (!rst_n)                     ctrl_q <= '0;
        else if (wr_en && word == W_CTRL) ctrl_q <= wdata[4:0] & M_CTRL[4:0];
    end

    // table base and flush words
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tbase_q  <= '0;
            flall_q  <= '0;
            flpage_q <= '0;
        end else if (wr_en) begin
            if (word == W_TBASE)  tbase_q  <= wdata & M_TBASE;
            if (word == W_FLALL)  flall_q  <= wdata;
            if (word == W_FLPAGE) flpage_q <= wdata;
        end
    end

    // arbiter enable, arbitration enable and OR-only mask-ID
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arbmsk_q <= RST_ARBMSK;
            arbon_q  <= F_ARBON;
            maskid_q <= RST_MASKID;
        end else if (wr_en) begin
            if (word == W_ARBMSK) arbmsk_q <= (wdata & M_ARBMSK) | F_ARBMSK;
            if (word == W_ARBON)  arbon_q  <= (wdata & M_ARBON) | F_ARBON;
            if (word == W_MASKID) maskid_q <= maskid_q | (wdata & M_MASKID);
        end
    end

    // one configuration word per slot
    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        always_comb slot_hit[g] = (word == W_SLOT0 + 32'(g));

        // slot word: masked store
        always_ff @(posedge clk) begin
            if (!rst_n)                   slot_q[g] <= '0;
            else if (wr_en && slot_hit[g]) slot_q[g] <= wdata & M_SLOT;
        end

        // p_slot_mask_r9: no bit outside the slot mask is ever set
        p_slot_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> ((slot_q[g] & ~M_SLOT) == '0));
    end

    // read mux over the configuration words
    always_comb begin
        rdata = '0;
        hit   = 1'b1;
        case (word)
            W_CTRL:   rdata = {VERSION, 19'h0, ctrl_q};
            W_TBASE:  rdata = tbase_q;
            W_FLALL:  rdata = flall_q;
            W_FLPAGE: rdata = flpage_q;
            W_ARBMSK: rdata = arbmsk_q;
            W_ARBON:  rdata = arbon_q;
            W_MASKID: rdata = maskid_q;
            default:  hit   = 1'b0;
        endcase
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (slot_hit[i]) begin
                rdata = slot_q[i];
                hit   = 1'b1;
            end
        end
    end

    always_comb ctrl_lo = ctrl_q;

    // p_arbmsk_bit0_r8: bit 0 of arbiter enable is hard-wired
    p_arbmsk_bit0_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> arbmsk_q[0]);
    // p_arbon_bit3_r10: bit 3 of arbitration enable is hard-wired
    p_arbon_bit3_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> arbon_q[3]);
    // p_maskid_keep_r11: mask-ID never loses a bit
    p_maskid_keep_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((maskid_q & $past(maskid_q)) == $past(maskid_q)));
endmodule

// File: rtl/dvma_csr.sv
// Top of the translation unit register block. Decodes the word port,
// splits accesses between the configuration and error-capture parts,
// keeps the window start decoded from the last control write, and merges
// read data. Unlisted words read zero. Assumes WORD_AW <= 32.
module dvma_csr
    import dvma_csr_pkg::*;
#(
    parameter logic [7:0] VERSION    = 8'h41,
    parameter int         WORD_AW    = 12,
    parameter int         NUM_SLOTS  = 4,
    parameter int         PAGE_SHIFT = 12,
    parameter int         MIN_LOG2   = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               acc_en,
    input  logic               acc_wr,
    input  logic [WORD_AW-1:0] acc_word,
    input  logic [31:0]        acc_wdata,
    output logic [31:0]        acc_rdata,
    input  logic               fault_pulse,
    input  logic               fault_rd,
    input  logic [31:0]        fault_addr,
    output logic [31:0]        win_start,
    output logic               xlat_en,
    output logic               irq
);
    logic [31:0] word;
    logic        wr_en, rd_en, is_stat, is_addr;
    logic [31:0] cfg_rdata, stat_q, addr_q, dec_start;
    logic        cfg_hit;
    logic [4:0]  ctrl_lo;

    // access decode
    always_comb begin
        word    = 32'(acc_word);
        wr_en   = acc_en && acc_wr;
        rd_en   = acc_en && !acc_wr;
        is_stat = (word == W_ESTAT);
        is_addr = (word == W_EADDR);
    end

    dvma_cfg_regs #(
        .VERSION   (VERSION),
        .NUM_SLOTS (NUM_SLOTS)
    ) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .word    (word),
        .wdata   (acc_wdata),
        .rdata   (cfg_rdata),
        .hit     (cfg_hit),
        .ctrl_lo (ctrl_lo)
    );

    dvma_fault_ctl #(
        .PAGE_SHIFT (PAGE_SHIFT)
    ) u_fault (
        .clk         (clk),
        .rst_n       (rst_n),
        .stat_wr     (wr_en && is_stat),
        .addr_wr     (wr_en && is_addr),
        .err_touch   ((wr_en || rd_en) && (is_stat || is_addr)),
        .wdata       (acc_wdata),
        .fault_pulse (fault_pulse),
        .fault_rd    (fault_rd),
        .fault_addr  (fault_addr),
        .stat_q      (stat_q),
        .addr_q      (addr_q),
        .irq         (irq)
    );

    dvma_win_dec #(
        .MIN_LOG2 (MIN_LOG2)
    ) u_win (
        .code  (acc_wdata[4:2]),
        .start (dec_start)
    );

    // window start: loaded from the written range code on control writes
    always_ff @(posedge clk) begin
        if (!rst_n)                      win_start <= '0;
        else if (wr_en && word == W_CTRL) win_start <= dec_start;
    end

    // read data merge; unlisted words read zero
    always_comb begin
        if (is_stat)      acc_rdata = stat_q;
        else if (is_addr) acc_rdata = addr_q;
        else if (cfg_hit) acc_rdata = cfg_rdata;
        else              acc_rdata = '0;
    end

    always_comb xlat_en = ctrl_lo[0];

    // p_win_hold_r3: the window start only moves on a control write
    p_win_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !(wr_en && word == W_CTRL)) |=> $stable(win_start));
    // p_win_align_r3: the low MIN_LOG2 bits of the window start stay zero
    p_win_align_r3: assert property (@(posedge clk) disable iff (!rst_n)
        win_start[MIN_LOG2-1:0] == '0);
endmodule

// File: tb/tb_dvma_csr.sv
// Self-checking bench for dvma_csr: sweeps of the masks, range codes and interrupt paths.
module tb_dvma_csr;
    localparam logic [7:0] VER = 8'h41;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_en = 1'b0, acc_wr = 1'b0;
    logic [11:0] acc_word = '0;
    logic [31:0] acc_wdata = '0;
    logic [31:0] acc_rdata;
    logic        fault_pulse = 1'b0, fault_rd = 1'b0;
    logic [31:0] fault_addr = '0;
    logic [31:0] win_start;
    logic        xlat_en, irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    dvma_csr #(.VERSION(VER)) dut (
        .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr),
        .acc_word(acc_word), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
        .fault_pulse(fault_pulse), .fault_rd(fault_rd), .fault_addr(fault_addr),
        .win_start(win_start), .xlat_en(xlat_en), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one write, taken at the next rising edge
    task automatic wr(input logic [11:0] w, input logic [31:0] d);
        @(negedge clk);
        acc_en = 1'b1; acc_wr = 1'b1; acc_word = w; acc_wdata = d;
        @(negedge clk);
        acc_en = 1'b0; acc_wr = 1'b0;
    endtask

    // look at a word without issuing a read
    task automatic peek(input logic [11:0] w, output logic [31:0] d);
        @(negedge clk);
        acc_word = w;
        #1 d = acc_rdata;
    endtask

    // issued read, with side effect at the next edge
    task automatic rd(input logic [11:0] w, output logic [31:0] d);
        @(negedge clk);
        acc_en = 1'b1; acc_wr = 1'b0; acc_word = w;
        #1 d = acc_rdata;
        @(negedge clk);
        acc_en = 1'b0;
    endtask

    task automatic fault(input logic r, input logic [31:0] a);
        @(negedge clk);
        fault_pulse = 1'b1; fault_rd = r; fault_addr = a;
        @(negedge clk);
        fault_pulse = 1'b0;
    endtask

    // walking one, all ones and all zeros against mask and forced bits
    task automatic sweep(input string tag, input logic [11:0] w,
                         input logic [31:0] m, input logic [31:0] f);
        logic [31:0] v;
        for (int b = 0; b < 32; b++) begin
            wr(w, 32'h1 << b);
            peek(w, v);
            chk(tag, v, ((32'h1 << b) & m) | f);
        end
        wr(w, 32'hFFFF_FFFF); peek(w, v); chk(tag, v, m | f);
        wr(w, 32'h0);         peek(w, v); chk(tag, v, f);
    endtask

    initial begin
        repeat (2000000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [31:0] wexp;
        repeat (4) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1 reset values
        peek(12'h000, v); chk("R1 ctrl", v, {VER, 24'h0});
        peek(12'h402, v); chk("R1 arbmsk", v, 32'h3);
        peek(12'h400, v); chk("R1 estat", v, 32'h0080_0000);
        peek(12'h800, v); chk("R1 arbon", v, 32'h8);
        peek(12'hC06, v); chk("R1 maskid", v, 32'h2300_0000);
        peek(12'h001, v); chk("R1 tbase", v, 32'h0);
        peek(12'h401, v); chk("R1 eaddr", v, 32'h0);
        chk("R1 win", win_start, 32'h0);
        chk("R1 irq", {31'h0, irq}, 32'h0);

        // R2 control mask and version
        sweep("R2 ctrl", 12'h000, 32'h1D, {VER, 24'h0});
        wr(12'h000, 32'h1); chk("R2 xlat_en", {31'h0, xlat_en}, 32'h1);
        wr(12'h000, 32'h0); chk("R2 xlat_en", {31'h0, xlat_en}, 32'h0);

        // R3 every range code, then a different code
        for (int c = 0; c < 8; c++) begin
            wr(12'h000, 32'(c) << 2);
            wexp = 32'hFFFF_FFFF << (24 + c);
            chk("R3 win", win_start, wexp);
            wr(12'h001, 32'((7 - c)) << 2);
            chk("R3 win hold", win_start, wexp);
            wr(12'h000, 32'((7 - c)) << 2);
            chk("R3 win", win_start, 32'hFFFF_FFFF << (31 - c));
        end

        // R4 base and flush words
        sweep("R4 tbase", 12'h001, 32'h07FF_FC00, 32'h0);
        sweep("R4 flall", 12'h005, 32'hFFFF_FFFF, 32'h0);
        sweep("R4 flpage", 12'h006, 32'hFFFF_FFFF, 32'h0);

        // R5 error status and address
        sweep("R5 estat", 12'h400, 32'hFF0F_FFFF, 32'h0080_0000);
        sweep("R5 eaddr", 12'h401, 32'hFFFF_FFFF, 32'h0);

        // R8, R9, R10 masked registers
        sweep("R8 arbmsk", 12'h402, 32'h801F_000F, 32'h1);
        for (int s = 0; s < 4; s++) sweep("R9 slot", 12'(12'h404 + s), 32'h0001_0003, 32'h0);
        wr(12'h404, 32'h1); wr(12'h405, 32'h2); wr(12'h406, 32'h10000); wr(12'h407, 32'h3);
        peek(12'h404, v); chk("R9 slot0", v, 32'h1);
        peek(12'h405, v); chk("R9 slot1", v, 32'h2);
        peek(12'h406, v); chk("R9 slot2", v, 32'h10000);
        peek(12'h407, v); chk("R9 slot3", v, 32'h3);
        sweep("R10 arbon", 12'h800, 32'h001F_0000, 32'h8);

        // R11 mask-ID OR-only
        wr(12'hC06, 32'h0000_00F0); peek(12'hC06, v); chk("R11 or", v, 32'h2300_00F0);
        wr(12'hC06, 32'hFF00_0F00); peek(12'hC06, v); chk("R11 or", v, 32'h2300_0FF0);
        wr(12'hC06, 32'h0);         peek(12'hC06, v); chk("R11 keep", v, 32'h2300_0FF0);

        // R12 unlisted words
        wr(12'h002, 32'hDEAD_BEEF); peek(12'h002, v); chk("R12 rd0", v, 32'h0);
        wr(12'h408, 32'hFFFF_FFFF); peek(12'h408, v); chk("R12 rd0", v, 32'h0);
        wr(12'hFFF, 32'hFFFF_FFFF); peek(12'hFFF, v); chk("R12 rd0", v, 32'h0);
        peek(12'h407, v); chk("R12 neighbour", v, 32'h3);
        peek(12'h001, v); chk("R12 tbase", v, 32'h0);

        // R7 read fault, R13 hold, R6 lowering by issued read of eaddr
        fault(1'b1, 32'h1234_5ABC);
        chk("R7 irq", {31'h0, irq}, 32'h1);
        peek(12'h400, v); chk("R7 estat rd", v, 32'hC086_0000);
        peek(12'h401, v); chk("R7 eaddr", v, 32'h1234_5000);
        rd(12'h000, v); wr(12'h001, 32'h0);
        chk("R13 hold", {31'h0, irq}, 32'h1);
        rd(12'h401, v); chk("R6 rd eaddr", {31'h0, irq}, 32'h0);

        // R7 write fault; R6 lowering by issued read of estat
        fault(1'b0, 32'hFFFF_FFFF);
        peek(12'h400, v); chk("R7 estat wr", v, 32'hC082_0000);
        peek(12'h401, v); chk("R7 eaddr", v, 32'hFFFF_F000);
        rd(12'h400, v); chk("R6 rd estat", {31'h0, irq}, 32'h0);
        repeat (3) @(negedge clk);
        chk("R13 low hold", {31'h0, irq}, 32'h0);

        // R6 lowering by writes
        fault(1'b0, 32'h0);
        wr(12'h400, 32'h0); chk("R6 wr estat", {31'h0, irq}, 32'h0);
        fault(1'b0, 32'h0);
        wr(12'h401, 32'h5); chk("R6 wr eaddr", {31'h0, irq}, 32'h0);

        // R7 fault wins over a same-cycle write
        @(negedge clk);
        acc_en = 1'b1; acc_wr = 1'b1; acc_word = 12'h400; acc_wdata = 32'h0;
        fault_pulse = 1'b1; fault_rd = 1'b1; fault_addr = 32'h0000_2FFF;
        @(negedge clk);
        acc_en = 1'b0; acc_wr = 1'b0; fault_pulse = 1'b0;
        chk("R7 priority irq", {31'h0, irq}, 32'h1);
        peek(12'h400, v); chk("R7 priority estat", v, 32'hC086_0000);
        peek(12'h401, v); chk("R7 priority eaddr", v, 32'h0000_2000);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule